// File: doc/BRIEF.md
# ALU with Compare Condition Latch

This block is the execute stage of a small teaching processor. It takes a first operand `a_i`, which comes from the source register. It takes a second operand `b_i`, which the decode logic has already chosen from an immediate or a second register. It also takes an operation code. From these it produces a result and a hint that the result should be written back.

Arithmetic, bitwise, shift and move operations are purely combinational. A compare operation writes nothing back. Instead, when `en_i` is high, it stores an unsigned equal/greater/less outcome in a three-bit latch on the clock edge.

A branch condition input is resolved against that stored outcome only, never against the operands presented in the same cycle. `take_o` therefore tells the program-counter logic whether a conditional branch issued after a compare should be taken. The register file, memory access and the program counter are outside the block.

Top module: `alu_cmp_unit`

## Requirements
- R1: Operation code 0 gives `a_i + b_i` and code 1 gives `a_i - b_i`, both wrapped modulo 2^WIDTH.
- R2: Code 2 gives the bitwise AND of the operands, code 3 the bitwise OR and code 4 the bitwise exclusive OR.
- R3: Code 5 gives `b_i` with every bit inverted and `a_i` has no effect on it; code 6 passes `b_i` through unchanged.
- R4: Code 7 shifts `a_i` left and code 8 shifts it right by `b_i` positions, filling with zeros. A shift amount of WIDTH or more gives zero.
- R5: When code 9 (compare) is presented with `en_i` high, the next clock edge stores unsigned equal, greater (`a_i > b_i`) and less (`a_i < b_i`) flags. Exactly one of these flags is set afterwards.
- R6: The stored flags keep their value on every edge where code 9 is not presented with `en_i` high. This includes a compare with `en_i` low and any other operation with `en_i` high.
- R7: Synchronous active-high `rst` clears all three stored flags, so after reset only the always condition is taken.
- R8: `wr_en_o` is high for codes 0 to 8. It is low for compare (9), branch pass-through (10), halt (11) and the unused codes 12 to 15, and whenever it is low `result_o` is zero.
- R9: `take_o` decodes `cond_i` as follows: 0 is always taken; 1 is taken when the stored equal flag is set; 2 (not equal) when the stored greater or less flag is set; 3 on stored greater; 4 on stored less. Only the stored flags are consulted, not the current operands.
- R10: `cond_i` values 5, 6 and 7 never take a branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Instruction valid; qualifies the compare latch update |
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | First operand (source register) |
| b_i | input | WIDTH | Second operand (immediate or register) |
| cond_i | input | 3 | Requested branch condition |
| result_o | output | WIDTH | Operation result |
| wr_en_o | output | 1 | Write-back hint |
| take_o | output | 1 | Branch decision from the stored compare outcome |

## Verification
On every cycle, the assertions check the following:
- the stored flags stay one-hot or empty;
- the flags change only on an enabled compare;
- an equal compare sets the equal flag;
- compare and the non-writing codes produce no write-back and a zero result;
- the always condition is always taken.

The values of the arithmetic, logic and shift results only show up in the bench's scenarios, which compare every cycle against a behavioural model. The same holds for the wrap at 2^WIDTH, the shift-amount boundary at WIDTH, and the rule that a branch follows an earlier compare rather than the current operands.

// File: rtl/alu_cmp_pkg.sv
package alu_cmp_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOT  = 4'd5,
        OP_MOV  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_CMP  = 4'd9,
        OP_BR   = 4'd10,
        OP_HALT = 4'd11
    } alu_op_e;

    typedef enum logic [2:0] {
        CND_ALWAYS = 3'd0,
        CND_EQ     = 3'd1,
        CND_NE     = 3'd2,
        CND_GT     = 3'd3,
        CND_LT     = 3'd4
    } br_cond_e;

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } cmp_flags_t;

    // Operations whose result is meant for the register file.
    function automatic logic op_writes(input logic [3:0] op);
        logic w;
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
            OP_NOT, OP_MOV, OP_SHL, OP_SHR: w = 1'b1;
            default:                        w = 1'b0;
        endcase
        return w;
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SHL) || (op == OP_SHR);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int SHW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH-1:0] LIMIT = WIDTH'(WIDTH);

    logic             too_far;
    logic [SHW-1:0]   amt;
    logic [WIDTH-1:0] sum, diff, shl, shr;

    assign too_far = (b_i >= LIMIT);
    assign amt     = b_i[SHW-1:0];
    assign sum     = a_i + b_i;
    assign diff    = a_i - b_i;
    assign shl     = too_far ? '0 : (a_i << amt);
    assign shr     = too_far ? '0 : (a_i >> amt);

    always_comb begin
        case (op_i)
            OP_ADD:  res_o = sum;
            OP_SUB:  res_o = diff;
            OP_SHL:  res_o = shl;
            OP_SHR:  res_o = shr;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            case (op_i)
                OP_AND:  res_o[i] = a_i[i] & b_i[i];
                OP_OR:   res_o[i] = a_i[i] | b_i[i];
                OP_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                OP_NOT:  res_o[i] = ~b_i[i];
                OP_MOV:  res_o[i] = b_i[i];
                default: res_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cmp_latch.sv
module cmp_latch
    import alu_cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output cmp_flags_t       flags_o
);
    cmp_flags_t nxt;

    always_comb begin
        nxt.eq = (a_i == b_i);
        nxt.gt = (a_i > b_i);
        nxt.lt = (a_i < b_i);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_o <= '0;
        else if (upd_i)
            flags_o <= nxt;
    end

    // R5: at most one outcome is ever recorded
    p_flags_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags_o));

    // R5: an equal compare leaves only the equal flag set
    p_equal_recorded_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (a_i == b_i)) |=> (flags_o.eq && !flags_o.gt && !flags_o.lt));

    // R6: without an enabled compare the flags hold
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(flags_o));
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_cmp_pkg::*;
(
    input  cmp_flags_t flags_i,
    input  logic [2:0] cond_i,
    output logic       take_o
);
    always_comb begin
        case (cond_i)
            CND_ALWAYS: take_o = 1'b1;
            CND_EQ:     take_o = flags_i.eq;
            CND_NE:     take_o = flags_i.gt | flags_i.lt;
            CND_GT:     take_o = flags_i.gt;
            CND_LT:     take_o = flags_i.lt;
            default:    take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
    import alu_cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       cond_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic             take_o
);
    logic [WIDTH-1:0] arith_res, logic_res;
    cmp_flags_t       flags;
    logic             cmp_upd;

    assign cmp_upd = en_i && (op_i == OP_CMP);

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(arith_res)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(logic_res)
    );

    cmp_latch #(.WIDTH(WIDTH)) u_latch (
        .clk(clk), .rst(rst), .upd_i(cmp_upd),
        .a_i(a_i), .b_i(b_i), .flags_o(flags)
    );

    branch_eval u_branch (
        .flags_i(flags), .cond_i(cond_i), .take_o(take_o)
    );

    always_comb begin
        wr_en_o = op_writes(op_i);
        if (!wr_en_o)
            result_o = '0;
        else if (op_is_arith(op_i))
            result_o = arith_res;
        else
            result_o = logic_res;
    end

    // R8: a compare never requests write-back
    p_cmp_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP) |-> !wr_en_o);

    // R8: a non-writing operation drives a zero result
    p_quiet_result_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en_o |-> (result_o == '0));

    // R9: the unconditional branch is always taken
    p_always_taken_r9: assert property (@(posedge clk) disable iff (rst)
        (cond_i == CND_ALWAYS) |-> take_o);

    // R10: reserved conditions are never taken
    p_reserved_cond_r10: assert property (@(posedge clk) disable iff (rst)
        (cond_i > 3'd4) |-> !take_o);
endmodule

// File: tb/sim_alu_cmp_unit.sv
`timescale 1ns/1ps
module sim_alu_cmp_unit;
    localparam int W = 16;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_i = 1'b0;
    logic [3:0]   op_i = 4'd11;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [2:0]   cond_i = 3'd0;
    logic [W-1:0] result_o;
    logic         wr_en_o;
    logic         take_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int m_eq = 0, m_gt = 0, m_lt = 0;

    always #10 clk = ~clk;

    alu_cmp_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .en_i(en_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .cond_i(cond_i), .result_o(result_o), .wr_en_o(wr_en_o), .take_o(take_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int ref_res(input int op, input int a, input int b);
        case (op)
            0: return (a + b) & MASK;
            1: return (a - b) & MASK;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return (~b) & MASK;
            6: return b;
            7: return (b >= W) ? 0 : ((a << b) & MASK);
            8: return (b >= W) ? 0 : (a >> b);
            default: return 0;
        endcase
    endfunction

    function automatic int ref_take(input int c);
        case (c)
            0: return 1;
            1: return m_eq;
            2: return m_gt | m_lt;
            3: return m_gt;
            4: return m_lt;
            default: return 0;
        endcase
    endfunction

    // One instruction per cycle: drive at negedge, compare mid-cycle, advance model at posedge.
    task automatic step(input int op, input int a, input int b, input int c, input int en,
                        input string tag);
        int wr;
        @(negedge clk);
        op_i = op[3:0]; a_i = a[W-1:0]; b_i = b[W-1:0]; cond_i = c[2:0]; en_i = en[0];
        #2;
        wr = (op <= 8) ? 1 : 0;
        check(tag, "result", int'(result_o), wr ? ref_res(op, a & MASK, b & MASK) : 0);
        check(tag, "wr_en", int'(wr_en_o), wr);
        check(tag, "take", int'(take_o), ref_take(c));
        @(posedge clk);
        if (en != 0 && op == 9) begin
            m_eq = ((a & MASK) == (b & MASK)) ? 1 : 0;
            m_gt = ((a & MASK) >  (b & MASK)) ? 1 : 0;
            m_lt = ((a & MASK) <  (b & MASK)) ? 1 : 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_i = 4'd11; en_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_eq = 0; m_gt = 0; m_lt = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R7: reset state, only "always" taken
        for (int c = 0; c < 8; c++) step(11, 0, 0, c, 0, "R7 reset");

        // R1: wrap-around
        step(0, 16'hFFFF, 2, 0, 1, "R1 add wrap");
        step(0, 16'h1234, 16'h0101, 0, 1, "R1 add");
        step(1, 1, 2, 0, 1, "R1 sub wrap");
        step(1, 16'h8000, 16'h0001, 0, 1, "R1 sub");
        // R2: logic
        step(2, 16'hF0F0, 16'hFF00, 0, 1, "R2 and");
        step(3, 16'hF0F0, 16'h0F00, 0, 1, "R2 or");
        step(4, 16'hAAAA, 16'hFF00, 0, 1, "R2 xor");
        // R3: not ignores a, mov passes b
        step(5, 16'h0000, 16'h00FF, 0, 1, "R3 not");
        step(5, 16'hFFFF, 16'h00FF, 0, 1, "R3 not ignores a");
        step(6, 16'h5555, 16'hBEEF, 0, 1, "R3 mov");
        // R4: shifts and range boundary
        step(7, 16'h0001, 15, 0, 1, "R4 shl 15");
        step(7, 16'h00F3, 4, 0, 1, "R4 shl 4");
        step(7, 16'hFFFF, 16, 0, 1, "R4 shl width");
        step(8, 16'h8000, 15, 0, 1, "R4 shr 15");
        step(8, 16'hFFFF, 16'hFFFF, 0, 1, "R4 shr huge");
        step(8, 16'hF000, 0, 0, 1, "R4 shr 0");

        // R5/R9: compare equal, then branch with unequal current operands
        step(9, 7, 7, 1, 1, "R8 cmp no write");
        step(11, 1, 2, 1, 0, "R9 eq from latch");
        step(11, 1, 2, 2, 0, "R9 ne from latch");
        step(9, 9, 3, 3, 1, "R5 cmp gt");
        step(11, 0, 5, 3, 0, "R9 gt");
        step(11, 0, 5, 4, 0, "R9 lt false");
        step(9, 16'h0001, 16'hFFFF, 4, 1, "R5 cmp lt unsigned");
        step(11, 0, 0, 4, 0, "R9 lt");
        step(11, 0, 0, 2, 0, "R9 ne");
        // R6: compare with enable low, and other ops, leave latch alone
        step(9, 5, 5, 1, 0, "R6 cmp disabled");
        step(11, 0, 0, 1, 0, "R6 eq stays false");
        step(0, 5, 5, 4, 1, "R6 add no update");
        step(10, 5, 5, 4, 1, "R6 branch no update");
        step(11, 0, 0, 4, 0, "R6 lt kept");
        // R8: non-writing codes
        for (int o = 9; o < 16; o++) step(o, 16'h1234, 16'h4321, 0, 0, "R8 no write");
        // R10: reserved conditions
        for (int c = 5; c < 8; c++) step(11, 0, 0, c, 0, "R10 reserved cond");

        // R7: reset mid-run clears the latch
        step(9, 3, 3, 0, 1, "R5 cmp eq before reset");
        do_reset();
        step(11, 0, 0, 1, 0, "R7 eq cleared");
        step(11, 0, 0, 2, 0, "R7 ne cleared");

        // R9: mixed random traffic against the model
        for (int i = 0; i < 400; i++) begin
            int bb;
            bb = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 20) : int'($urandom & MASK);
            step($urandom_range(0, 15), int'($urandom & MASK), bb,
                 $urandom_range(0, 7), $urandom_range(0, 1), "R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule